// File: doc/BRIEF.md
# Halt Mode Wake Controller

This block decides whether a halt request from the processor puts a small microcontroller into its deepest power state. While the device is halted it removes the enables for the main oscillator, the processor clock and the internally clocked peripherals. A halt request is honoured only when the oscillator-interrupt-enable status bit is clear. A watchdog that is running and whose halt-compatibility option is clear turns the request into a watchdog reset. On entry the controller writes a fixed value into the processor's two-bit interrupt mask, so that interrupts are enabled during the halt.

A wake-up can come from the reset request line or from any pending interrupt whose line is marked wake-capable by a parameter. When a wake-up arrives, the oscillator restarts at once and the processor stays stopped for a stabilisation interval. A static input chooses a short or a long interval. When the interval ends, the controller issues a one-cycle command. That command tells the processor either to fetch the reset vector or to service the waking interrupt. If a wake source is already present when the halt is accepted, the controller goes straight into stabilisation and never switches the oscillator off.

Top module: `halt_wake_ctrl`

## Requirements
- R1: A halt request is accepted only when `osc_irq_en_i` is 0. With `osc_irq_en_i` at 1 the state stays RUN, no pulse is produced and every clock enable stays high.
- R2: In the cycle the state first leaves RUN for HALT or STAB, `imask_wr_o` is high for exactly that cycle and `imask_o` reads binary 10.
- R3: If the reset request or a wake-capable interrupt is present when the halt is accepted, the next state is STAB (code 2) and not HALT.
- R4: In HALT (code 1), `osc_en_o`, `cpu_clk_en_o` and `periph_clk_en_o` are all 0.
- R5: In HALT, only `ext_reset_i` or an `irq_pend_i` bit that is set in `WAKE_MASK` (default: bits 0 to 3) causes a wake-up. Any other pending bit leaves the state in HALT.
- R6: STAB lasts exactly 256 cycles when `long_delay_i` is 0 and 4096 cycles when it is 1. During STAB, `osc_en_o` is 1 and both other enables are 0. `stab_done_o` pulses once, in the last STAB cycle.
- R7: After STAB the state is RUN and exactly one of `fetch_reset_o` (reset wake) or `service_irq_o` (interrupt wake) is high for one cycle. `wake_cause_o` reads 1 for reset and 0 for interrupt. Reset wins when both sources arrive together.
- R8: An accepted halt request with `wdg_en_i`=1 and `wdg_halt_opt_i`=0 produces a one-cycle `wdg_rst_o` pulse in the next cycle. The state stays RUN and no mask write occurs.
- R9: With `wdg_halt_opt_i`=1 or `wdg_en_i`=0 the halt is entered normally, and `wdg_hold_o` is 1 in every cycle outside RUN.
- R10: An asynchronous low on `rst_ni` forces state RUN (code 0), all clock enables to 1, `wake_cause_o` to 0 and all pulse outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock (restarted oscillator domain) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_req_i | input | 1 | Halt instruction strobe from the processor |
| osc_irq_en_i | input | 1 | Oscillator-interrupt-enable status bit |
| wdg_en_i | input | 1 | Watchdog is running |
| wdg_halt_opt_i | input | 1 | Watchdog halt-compatibility option |
| long_delay_i | input | 1 | Static: 0 selects 256, 1 selects 4096 stabilisation cycles |
| ext_reset_i | input | 1 | Reset request acting as a wake source |
| irq_pend_i | input | NIRQ | Pending interrupt lines |
| state_o | output | 2 | Power state: 0 RUN, 1 HALT, 2 STAB |
| osc_en_o | output | 1 | Main oscillator enable |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| periph_clk_en_o | output | 1 | Internal peripheral clock enable |
| imask_wr_o | output | 1 | Interrupt-mask write strobe |
| imask_o | output | 2 | Value written into the interrupt mask |
| wdg_rst_o | output | 1 | Watchdog reset pulse |
| wdg_hold_o | output | 1 | Watchdog held inactive |
| stab_done_o | output | 1 | Last cycle of stabilisation |
| fetch_reset_o | output | 1 | Command: fetch the reset vector |
| service_irq_o | output | 1 | Command: service the waking interrupt |
| wake_cause_o | output | 1 | Last wake cause, 1 reset, 0 interrupt |

## Verification
The assertions check on every cycle that the clock enables match the state, that a blocked or diverted request keeps the state in RUN, that a request arriving with a wake source present goes straight to stabilisation, and that a non-qualifying interrupt leaves HALT undisturbed. The checker also counts each stabilisation interval independently and confirms its length when it ends. The bench scenarios cover the rest: the end-to-end sequences of entry, wake and resume for both delay lengths, the choice of resume command after a simultaneous reset and interrupt, and an asynchronous reset taken in the middle of stabilisation.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_HALT = 2'd1,
    PS_STAB = 2'd2
  } pstate_e;

  typedef enum logic {
    WC_IRQ = 1'b0,
    WC_RST = 1'b1
  } wcause_e;

  localparam logic [1:0] HALT_IMASK = 2'b10;

  // Stabilisation length in cycles for the selected option.
  function automatic int unsigned stab_len(input logic sel_long,
                                           input int unsigned short_c,
                                           input int unsigned long_c);
    return sel_long ? long_c : short_c;
  endfunction

endpackage

// File: rtl/hwc_entry_gate.sv
module hwc_entry_gate (
  input  logic halt_req_i,
  input  logic osc_irq_en_i,
  input  logic wdg_en_i,
  input  logic wdg_halt_opt_i,
  input  logic wake_now_i,
  output logic go_halt_o,
  output logic go_stab_o,
  output logic wdg_trip_o
);
  logic accept;
  logic enter;

  always_comb begin
    accept     = halt_req_i & ~osc_irq_en_i;
    wdg_trip_o = accept & wdg_en_i & ~wdg_halt_opt_i;
    enter      = accept & ~wdg_trip_o;
    go_stab_o  = enter & wake_now_i;
    go_halt_o  = enter & ~wake_now_i;
  end
endmodule

// File: rtl/hwc_wake_qual.sv
module hwc_wake_qual #(
  parameter int unsigned NIRQ = 8,
  parameter logic [NIRQ-1:0] WAKE_MASK = 8'h0F
) (
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic            ext_reset_i,
  output logic            wake_now_o,
  output logic            cause_rst_o
);
  logic [NIRQ-1:0] qual;

  for (genvar g = 0; g < NIRQ; g++) begin : g_qual
    if (WAKE_MASK[g]) begin : g_cap
      assign qual[g] = irq_pend_i[g];
    end else begin : g_nocap
      assign qual[g] = 1'b0;
    end
  end

  assign cause_rst_o = ext_reset_i;
  assign wake_now_o  = ext_reset_i | (|qual);
endmodule

// File: rtl/hwc_stab_timer.sv
module hwc_stab_timer #(
  parameter int unsigned SHORT_CYC = 256,
  parameter int unsigned LONG_CYC  = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic sel_long_i,
  output logic done_o
);
  import hwc_pkg::*;
  localparam int unsigned CNT_W = $clog2(LONG_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit  = CNT_W'(stab_len(sel_long_i, SHORT_CYC, LONG_CYC) - 1);
  assign done_o = active_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!active_i || done_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int unsigned NIRQ = 8,
  parameter logic [NIRQ-1:0] WAKE_MASK = 8'h0F,
  parameter int unsigned SHORT_CYC = 256,
  parameter int unsigned LONG_CYC  = 4096
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            halt_req_i,
  input  logic            osc_irq_en_i,
  input  logic            wdg_en_i,
  input  logic            wdg_halt_opt_i,
  input  logic            long_delay_i,
  input  logic            ext_reset_i,
  input  logic [NIRQ-1:0] irq_pend_i,
  output logic [1:0]      state_o,
  output logic            osc_en_o,
  output logic            cpu_clk_en_o,
  output logic            periph_clk_en_o,
  output logic            imask_wr_o,
  output logic [1:0]      imask_o,
  output logic            wdg_rst_o,
  output logic            wdg_hold_o,
  output logic            stab_done_o,
  output logic            fetch_reset_o,
  output logic            service_irq_o,
  output logic            wake_cause_o
);
  import hwc_pkg::*;

  pstate_e state_q, state_d;
  wcause_e cause_q, cause_d;
  logic    go_halt, go_stab, wdg_trip;
  logic    wake_now, cause_rst;
  logic    stab_done;
  logic    imask_wr_q, wdg_rst_q, fetch_q, svc_q;

  hwc_wake_qual #(.NIRQ(NIRQ), .WAKE_MASK(WAKE_MASK)) u_qual (
    .irq_pend_i (irq_pend_i),
    .ext_reset_i(ext_reset_i),
    .wake_now_o (wake_now),
    .cause_rst_o(cause_rst)
  );

  hwc_entry_gate u_gate (
    .halt_req_i    (halt_req_i),
    .osc_irq_en_i  (osc_irq_en_i),
    .wdg_en_i      (wdg_en_i),
    .wdg_halt_opt_i(wdg_halt_opt_i),
    .wake_now_i    (wake_now),
    .go_halt_o     (go_halt),
    .go_stab_o     (go_stab),
    .wdg_trip_o    (wdg_trip)
  );

  hwc_stab_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (state_q == PS_STAB),
    .sel_long_i(long_delay_i),
    .done_o    (stab_done)
  );

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      PS_RUN: begin
        if (go_stab) begin
          state_d = PS_STAB;
          cause_d = cause_rst ? WC_RST : WC_IRQ;
        end else if (go_halt) begin
          state_d = PS_HALT;
        end
      end
      PS_HALT: begin
        if (wake_now) begin
          state_d = PS_STAB;
          cause_d = cause_rst ? WC_RST : WC_IRQ;
        end
      end
      PS_STAB: if (stab_done) state_d = PS_RUN;
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PS_RUN;
      cause_q    <= WC_IRQ;
      imask_wr_q <= 1'b0;
      wdg_rst_q  <= 1'b0;
      fetch_q    <= 1'b0;
      svc_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      cause_q    <= cause_d;
      imask_wr_q <= (state_q == PS_RUN) && (go_halt || go_stab);
      wdg_rst_q  <= (state_q == PS_RUN) && wdg_trip;
      fetch_q    <= (state_q == PS_STAB) && stab_done && (cause_q == WC_RST);
      svc_q      <= (state_q == PS_STAB) && stab_done && (cause_q == WC_IRQ);
    end
  end

  assign state_o         = state_q;
  assign osc_en_o        = (state_q != PS_HALT);
  assign cpu_clk_en_o    = (state_q == PS_RUN);
  assign periph_clk_en_o = (state_q == PS_RUN);
  assign imask_wr_o      = imask_wr_q;
  assign imask_o         = HALT_IMASK;
  assign wdg_rst_o       = wdg_rst_q;
  assign wdg_hold_o      = (state_q != PS_RUN);
  assign stab_done_o     = stab_done;
  assign fetch_reset_o   = fetch_q;
  assign service_irq_o   = svc_q;
  assign wake_cause_o    = cause_q;
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
  parameter int unsigned NIRQ = 8,
  parameter logic [NIRQ-1:0] WAKE_MASK = 8'h0F,
  parameter int unsigned SHORT_CYC = 256,
  parameter int unsigned LONG_CYC  = 4096
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            halt_req_i,
  input logic            osc_irq_en_i,
  input logic            wdg_en_i,
  input logic            wdg_halt_opt_i,
  input logic            long_delay_i,
  input logic            ext_reset_i,
  input logic [NIRQ-1:0] irq_pend_i,
  input logic [1:0]      state_o,
  input logic            osc_en_o,
  input logic            cpu_clk_en_o,
  input logic            periph_clk_en_o,
  input logic            imask_wr_o,
  input logic [1:0]      imask_o,
  input logic            wdg_rst_o,
  input logic            wdg_hold_o,
  input logic            stab_done_o,
  input logic            fetch_reset_o,
  input logic            service_irq_o
);
  logic [15:0] mon_len;
  logic        wake_src;
  logic        blocked, tripped, entering;

  assign wake_src = ext_reset_i || ((irq_pend_i & WAKE_MASK) != '0);
  assign blocked  = (state_o == 2'd0) && halt_req_i && osc_irq_en_i;
  assign tripped  = (state_o == 2'd0) && halt_req_i && !osc_irq_en_i
                    && wdg_en_i && !wdg_halt_opt_i;
  assign entering = (state_o == 2'd0) && halt_req_i && !osc_irq_en_i
                    && !(wdg_en_i && !wdg_halt_opt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mon_len <= '0;
    else         mon_len <= (state_o == 2'd2) ? mon_len + 16'd1 : 16'd0;
  end

  AST_NO_ENTRY_WITH_OIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |=> (state_o == 2'd0) && !imask_wr_o && !wdg_rst_o); // R1
  AST_MASK_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entering |=> imask_wr_o && (imask_o == 2'b10)); // R2
  AST_IMMEDIATE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entering && wake_src) |=> (state_o == 2'd2)); // R3
  AST_HALT_CLOCKS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1) |-> !osc_en_o && !cpu_clk_en_o && !periph_clk_en_o); // R4
  AST_NONQUAL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 2'd1) && !wake_src) |=> (state_o == 2'd1)); // R5
  AST_STAB_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |-> osc_en_o && !cpu_clk_en_o && !periph_clk_en_o); // R6
  AST_STAB_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stab_done_o |-> (32'(mon_len) + 1 == (long_delay_i ? LONG_CYC : SHORT_CYC))); // R6
  AST_ONE_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fetch_reset_o, service_irq_o})); // R7
  AST_RESUME_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stab_done_o |=> (state_o == 2'd0) && (fetch_reset_o || service_irq_o)); // R7
  AST_WDG_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tripped |=> wdg_rst_o && (state_o == 2'd0) && !imask_wr_o); // R8
  AST_WDG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'd0) |-> wdg_hold_o); // R9
endmodule

bind halt_wake_ctrl hwc_checker #(
  .NIRQ(NIRQ), .WAKE_MASK(WAKE_MASK), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .halt_req_i(halt_req_i),
  .osc_irq_en_i(osc_irq_en_i), .wdg_en_i(wdg_en_i),
  .wdg_halt_opt_i(wdg_halt_opt_i), .long_delay_i(long_delay_i),
  .ext_reset_i(ext_reset_i), .irq_pend_i(irq_pend_i), .state_o(state_o),
  .osc_en_o(osc_en_o), .cpu_clk_en_o(cpu_clk_en_o),
  .periph_clk_en_o(periph_clk_en_o), .imask_wr_o(imask_wr_o),
  .imask_o(imask_o), .wdg_rst_o(wdg_rst_o), .wdg_hold_o(wdg_hold_o),
  .stab_done_o(stab_done_o), .fetch_reset_o(fetch_reset_o),
  .service_irq_o(service_irq_o)
);

// File: tb/halt_wake_ctrl_test.sv
module halt_wake_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_req = 0, osc_ie = 0, wdg_en = 0, wdg_opt = 0, long_dl = 0, ext_rst = 0;
  logic [7:0] irq = '0;
  logic [1:0] state, imask;
  logic       osc_en, cpu_en, per_en, imask_wr, wdg_rst, wdg_hold, done, fetch, svc, cause;
  int         checks = 0, errors = 0;
  bit         finished = 0;

  always #2 clk = ~clk;

  halt_wake_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .halt_req_i(halt_req), .osc_irq_en_i(osc_ie),
    .wdg_en_i(wdg_en), .wdg_halt_opt_i(wdg_opt), .long_delay_i(long_dl),
    .ext_reset_i(ext_rst), .irq_pend_i(irq), .state_o(state), .osc_en_o(osc_en),
    .cpu_clk_en_o(cpu_en), .periph_clk_en_o(per_en), .imask_wr_o(imask_wr),
    .imask_o(imask), .wdg_rst_o(wdg_rst), .wdg_hold_o(wdg_hold),
    .stab_done_o(done), .fetch_reset_o(fetch), .service_irq_o(svc),
    .wake_cause_o(cause)
  );

  // bit7 osc_ie, 6 wdg_en, 5 opt, 4 wake pending, 3:2 next state, 1 wdg pulse, 0 mask write
  localparam logic [7:0] VEC [8] = '{
    8'b1000_00_00, 8'b1100_00_00, 8'b0000_01_01, 8'b0100_00_10,
    8'b0110_01_01, 8'b0011_10_01, 8'b0101_00_10, 8'b1011_00_00 };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; #1; rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic enter_halt();
    halt_req = 1; tick(); halt_req = 0;
  endtask

  // Counts STAB cycles and done pulses; leaves bench in first RUN cycle.
  task automatic run_stab(input string req, input int exp_len);
    int n = 0, pulses = 0;
    while (state == 2'd2 && n < 10000) begin
      if (done) pulses++;
      n++;
      tick();
    end
    chk({req, " stab length"}, n, exp_len);
    chk({req, " done pulses"}, pulses, 1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R10 reset values
    chk("R10 state", state, 0);
    chk("R10 enables", {osc_en, cpu_en, per_en}, 3'b111);
    chk("R10 pulses", {imask_wr, wdg_rst, fetch, svc, cause}, 0);
    rst_n = 1'b1; @(negedge clk);

    foreach (VEC[i]) begin
      logic [7:0] v = VEC[i];
      do_reset();
      osc_ie = v[7]; wdg_en = v[6]; wdg_opt = v[5];
      irq = v[4] ? 8'h04 : 8'h00;
      halt_req = 1; tick(); halt_req = 0;
      chk($sformatf("R1/R3 vec%0d state", i), state, v[3:2]);
      chk($sformatf("R8 vec%0d wdg pulse", i), wdg_rst, v[1]);
      chk($sformatf("R2 vec%0d mask write", i), imask_wr, v[0]);
      if (v[0]) chk($sformatf("R2 vec%0d mask value", i), imask, 2);
      if (v[7]) chk($sformatf("R1 vec%0d clocks", i), {osc_en, cpu_en, per_en}, 3'b111);
      tick();
      chk($sformatf("R2/R8 vec%0d pulses end", i), {imask_wr, wdg_rst}, 0);
      irq = '0; osc_ie = 0; wdg_en = 0; wdg_opt = 0;
    end

    // Interrupt wake, short delay, watchdog option set
    do_reset();
    wdg_en = 1; wdg_opt = 1; long_dl = 0;
    enter_halt();
    chk("R9 halt entered", state, 1);
    chk("R4 clocks off", {osc_en, cpu_en, per_en}, 3'b000);
    chk("R9 hold", wdg_hold, 1);
    irq = 8'hF0;
    repeat (5) tick();
    chk("R5 non-wake irq ignored", state, 1);
    irq = 8'h04; tick(); irq = '0;
    chk("R6 stab state", state, 2);
    chk("R6 stab clocks", {osc_en, cpu_en, per_en}, 3'b100);
    chk("R9 hold in stab", wdg_hold, 1);
    run_stab("R6 short", 256);
    chk("R7 run after stab", state, 0);
    chk("R7 irq resume", {fetch, svc}, 2'b01);
    chk("R7 cause irq", cause, 0);
    tick();
    chk("R7 single pulse", {fetch, svc}, 0);

    // Reset and interrupt together, long delay
    wdg_en = 0; wdg_opt = 0; long_dl = 1;
    enter_halt();
    ext_rst = 1; irq = 8'h01; tick(); ext_rst = 0; irq = '0;
    run_stab("R6 long", 4096);
    chk("R7 reset resume", {fetch, svc}, 2'b10);
    chk("R7 cause reset", cause, 1);

    // Async reset in the middle of stabilisation
    long_dl = 0;
    enter_halt();
    irq = 8'h08; tick(); irq = '0;
    repeat (10) tick();
    rst_n = 0; #1;
    chk("R10 async state", state, 0);
    chk("R10 async clocks", {osc_en, cpu_en, per_en}, 3'b111);
    rst_n = 1; @(negedge clk);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule